// File: doc/BRIEF.md
# Shared-Line Asynchronous Memory Slave

This block lets a logic-side register file appear to an external host as a 16-bit pseudo-static memory. The host drives a single set of 16 lines that first carry an address and then carry data. Its strobes (address latch, chip select, read enable, write enable and two byte-lane enables, all active low) are not related to the local clock. Each strobe and the incoming lines are brought into the local clock through a two-flop synchronizer. Edge detection then decides when to latch the address, when to commit a write, and when to drive read data back.

The host runs with a fixed timing budget: an address phase of 2 cycles, an address hold of 1 cycle, a data phase of 4 cycles and a 1-cycle turnaround. The slave samples and drives inside those windows. The shared lines are modelled as a sampled input (`bus_in`), a driven value (`bus_out`) and a drive enable (`bus_oe`); the pad-level tristate sits outside the block. Storage is 16 words of 16 bits, selected by the low four address bits.

Top module: `muxbus_psram_slave`

## Requirements
- R1: After reset, `bus_oe` is 0, `bus_out` is 0 and every storage word reads back as 0x0000.
- R2: The address is taken when the synchronized latch strobe rises while the synchronized chip select is low. The value taken is the one on the lines the cycle before that rise. A latch-strobe pulse with chip select high leaves the address unchanged.
- R3: Only address bits 3:0 select a word; bits 15:4 are ignored, so addresses with equal low nibbles alias.
- R4: A write with both byte enables low stores all 16 data bits at the latched address.
- R5: Byte enable bit 0 low enables bits 7:0 and byte enable bit 1 low enables bits 15:8. A lane whose enable is high keeps its old contents. Both enables high change nothing.
- R6: A write commits exactly once per write-enable assertion, using the data and byte enables present when the falling edge was seen. Data changed later in the same assertion is not stored.
- R7: A write-enable pulse while chip select is high does not change storage.
- R8: `bus_oe` rises on the third clock edge after read enable and chip select are both low, and `bus_out` then carries the word at the latched address.
- R9: `bus_oe` falls on the third clock edge after either read enable or chip select goes high. Whenever `bus_oe` is 0, `bus_out` is 0x0000.
- R10: `bus_oe` stays 0 for the whole of a write access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 16 | Sampled value of the shared address/data lines |
| bus_out | output | 16 | Read data to place on the shared lines |
| bus_oe | output | 1 | High while the slave drives the shared lines |
| adv_n | input | 1 | Address-latch strobe, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read enable, active low |
| we_n | input | 1 | Write enable, active low |
| be_n | input | 2 | Byte-lane enables, active low (bit 0 low byte, bit 1 high byte) |

## Verification
Writes are tried with every byte-enable pattern. The full-word, low-only and high-only patterns each leave a different word behind, and the none-enabled pattern proves the masking cannot be bypassed. Addresses that differ only above bit 3 are used to separate true indexing from aliasing. Latch and write strobes pulsed with chip select high show that the select qualifies both. Read-enable timing is sampled one edge before and on the expected edge, in both directions, so an extra or missing synchronizer stage shows up as a mismatch.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  localparam int WORD_W  = 16;
  localparam int LANE_W  = 8;
  localparam int LANES   = WORD_W / LANE_W;

  // Merge new data into an old word, lane by lane, where an enable bit of 0 selects the new lane.
  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [LANES-1:0]  en_n);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int l = 0; l < LANES; l++) begin
      if (!en_n[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/muxbus_sync.sv
module muxbus_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/muxbus_regfile.sv
module muxbus_regfile
  import muxbus_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_be_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        mem_q[g] <= lane_merge(mem_q[g], wr_data, wr_be_n);
      end
    end
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/muxbus_psram_slave.sv
module muxbus_psram_slave
  import muxbus_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] bus_in,
  output logic [WORD_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  be_n
);
  // synchronized strobes, order {adv, ce, oe, we}
  logic [3:0]        strb_s;
  logic              adv_s, ce_s, oe_s, we_s;
  logic [LANES-1:0]  be_s;
  logic [WORD_W-1:0] dat_s;

  muxbus_sync #(.W(4), .RST_VAL(4'b1111)) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .async_i({adv_n, ce_n, oe_n, we_n}), .sync_o(strb_s));
  muxbus_sync #(.W(LANES), .RST_VAL({LANES{1'b1}})) u_be_sync (
    .clk(clk), .rst_n(rst_n), .async_i(be_n), .sync_o(be_s));
  muxbus_sync #(.W(WORD_W), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .async_i(bus_in), .sync_o(dat_s));

  assign {adv_s, ce_s, oe_s, we_s} = strb_s;

  // one extra stage for edge detection; the address lane stage is aligned with it
  logic             adv_d, we_d;
  logic [IDX_W-1:0] adr_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_d <= 1'b1;
      we_d  <= 1'b1;
      adr_d <= '0;
    end else begin
      adv_d <= adv_s;
      we_d  <= we_s;
      adr_d <= dat_s[IDX_W-1:0];
    end
  end

  // named events, visible to the checker
  logic adr_capture, wr_commit, rd_req;
  assign adr_capture = adv_s & ~adv_d & ~ce_s;
  assign wr_commit   = ~we_s & we_d & ~ce_s;
  assign rd_req      = ~ce_s & ~oe_s;

  logic [IDX_W-1:0] addr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           addr_q <= '0;
    else if (adr_capture) addr_q <= adr_d;
  end

  logic [WORD_W-1:0] rd_word;
  muxbus_regfile #(.DEPTH(DEPTH)) u_regfile (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_commit), .wr_idx(addr_q), .wr_data(dat_s), .wr_be_n(be_s),
    .rd_idx(addr_q), .rd_data(rd_word));

  logic              oe_q;
  logic [WORD_W-1:0] out_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      out_q <= '0;
    end else begin
      oe_q  <= rd_req;
      out_q <= rd_req ? rd_word : '0;
    end
  end

  assign bus_oe  = oe_q;
  assign bus_out = out_q;
endmodule

// File: rtl/muxbus_psram_slave_chk.sv
module muxbus_psram_slave_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic             wr_commit,
  input logic             adr_capture,
  input logic             ce_s,
  input logic [IDX_W-1:0] addr_q,
  input logic             bus_oe,
  input logic [15:0]      bus_out
);
  a_r8_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_oe);
  a_r9_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_oe);
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == 16'h0000));
  a_r6_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);
  a_r7_commit_selected: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !ce_s);
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adr_capture |=> $stable(addr_q));
endmodule

bind muxbus_psram_slave muxbus_psram_slave_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_commit(wr_commit),
  .adr_capture(adr_capture), .ce_s(ce_s), .addr_q(addr_q),
  .bus_oe(bus_oe), .bus_out(bus_out));

// File: tb/muxbus_psram_slave_tb.sv
module muxbus_psram_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_in = '0;
  logic [15:0] bus_out;
  logic        bus_oe;
  logic        adv_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [1:0]  be_n = 2'b11;

  int n_chk = 0;
  int n_bad = 0;
  logic in_write = 1'b0;
  logic oe_in_write = 1'b0;

  always #4 clk = ~clk;

  muxbus_psram_slave dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .adv_n(adv_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .be_n(be_n));

  always @(negedge clk) if (in_write && bus_oe) oe_in_write = 1'b1;

  // vector: {is_write, addr[15:0], data[15:0], be_n[1:0], expect[15:0]}
  localparam int NV = 11;
  localparam logic [50:0] VEC [NV] = '{
    {1'b1, 16'h0003, 16'h1234, 2'b00, 16'h0000},
    {1'b0, 16'h0003, 16'h0000, 2'b11, 16'h1234},
    {1'b1, 16'h0005, 16'hABCD, 2'b10, 16'h0000},
    {1'b0, 16'h0005, 16'h0000, 2'b11, 16'h00CD},
    {1'b1, 16'h0005, 16'h5600, 2'b01, 16'h0000},
    {1'b0, 16'h0005, 16'h0000, 2'b11, 16'h56CD},
    {1'b1, 16'h0005, 16'hFFFF, 2'b11, 16'h0000},
    {1'b0, 16'h0005, 16'h0000, 2'b11, 16'h56CD},
    {1'b1, 16'h0F1A, 16'h0BEE, 2'b00, 16'h0000},
    {1'b0, 16'h000A, 16'h0000, 2'b11, 16'h0BEE},
    {1'b0, 16'h777F, 16'h0000, 2'b11, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [15:0] a);
    ce_n = 1'b0; adv_n = 1'b0; bus_in = a;
    cyc(2);
    adv_n = 1'b1;
    cyc(1);
  endtask

  task automatic write_data(input logic [15:0] d, input logic [1:0] b);
    in_write = 1'b1;
    bus_in = d; be_n = b; we_n = 1'b0;
    cyc(4);
    we_n = 1'b1; ce_n = 1'b1; be_n = 2'b11;
    cyc(4);
    in_write = 1'b0;
  endtask

  task automatic read_word(input string req, input logic [15:0] exp);
    oe_n = 1'b0; ce_n = 1'b0; bus_in = 16'h0000;
    cyc(4);
    check(req, {31'd0, bus_oe}, 32'd1);
    check(req, {16'd0, bus_out}, {16'd0, exp});
    oe_n = 1'b1; ce_n = 1'b1;
    cyc(4);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1: reset state
    check("R1 oe", {31'd0, bus_oe}, 32'd0);
    check("R1 out", {16'd0, bus_out}, 32'd0);
    addr_phase(16'h0009);
    read_word("R1 cleared", 16'h0000);

    // table walk: R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      addr_phase(VEC[i][49:34]);
      if (VEC[i][50]) write_data(VEC[i][33:18], VEC[i][17:16]);
      else begin
        read_word($sformatf("R3/R4/R5 vec%0d", i), VEC[i][15:0]);
      end
    end

    // R6: data changed after the edge is not stored
    addr_phase(16'h0002);
    in_write = 1'b1;
    bus_in = 16'hC0DE; be_n = 2'b00; we_n = 1'b0;
    cyc(3);
    bus_in = 16'hDEAD;
    cyc(3);
    we_n = 1'b1; ce_n = 1'b1; be_n = 2'b11;
    cyc(4);
    in_write = 1'b0;
    addr_phase(16'h0002);
    read_word("R6 first data kept", 16'hC0DE);

    // R7: write strobe with chip select high
    in_write = 1'b1;
    ce_n = 1'b1; bus_in = 16'h9999; be_n = 2'b00; we_n = 1'b0;
    cyc(4);
    we_n = 1'b1; be_n = 2'b11;
    cyc(4);
    in_write = 1'b0;
    read_word("R7 unselected write", 16'hC0DE);

    // R2: latch pulse with chip select high keeps address 2
    ce_n = 1'b1; adv_n = 1'b0; bus_in = 16'h0003;
    cyc(2);
    adv_n = 1'b1;
    cyc(4);
    read_word("R2 unselected latch", 16'hC0DE);

    // R8 / R9: exact drive timing at address 3 (holds 0x1234)
    addr_phase(16'h0003);
    oe_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check("R8 not yet", {31'd0, bus_oe}, 32'd0);
    @(posedge clk); #1;
    check("R8 on", {31'd0, bus_oe}, 32'd1);
    check("R8 data", {16'd0, bus_out}, 32'h1234);
    @(negedge clk);
    oe_n = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R9 still on", {31'd0, bus_oe}, 32'd1);
    @(posedge clk); #1;
    check("R9 off", {31'd0, bus_oe}, 32'd0);
    check("R9 zero", {16'd0, bus_out}, 32'd0);
    ce_n = 1'b1;
    cyc(3);

    // R10
    check("R10 no drive in write", {31'd0, oe_in_write}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule